// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences the power-down states of a small processor subsystem. It watches a SLEEP instruction strobe, a standby-select bit, a set of per-module stop bits, a real-time-clock start bit, an active-low hardware-standby pin and a vector of wake-up sources. From these it drives the clock-generator enable, the CPU halt, one clock gate per peripheral, a keep-alive gate for the real-time clock, and a request that switches external memory between auto-refresh and self-refresh. A two-bit code on `mode_code` reports the current mode.

There are four low-power conditions. Sleep halts the CPU and leaves clocks and peripherals running. Software standby stops the clock generator and every peripheral and puts memory in self-refresh. Per-module stop bits gate single peripherals while the CPU keeps running. Hardware standby is entered from the pin and is left only by a power-on reset. Leaving software standby passes through a settling interval of programmable length. During this interval the oscillator runs again, but the CPU stays halted and memory stays in self-refresh. A power-on reset returns everything to run at once. A manual reset ends the software modes but keeps memory refresh going.

The block itself runs on an always-on clock. Interrupt priority, the refresh controller, the clock generator and the retention of register contents belong to neighbouring logic.

Top module: `lpm_sequencer`

## Requirements
- R1: While `rst_n` is low, and from the moment it falls, the outputs are `mode_code`=0, `cpg_en`=1, `cpu_halt`=0, `per_clk_en` all ones, `rtc_clk_en`=0 and `mem_self_refresh`=0. This applies in every mode, hardware standby included.
- R2: In run, a `sleep_stb` with `stby_sel`=0 enters sleep at the next clock edge: `mode_code`=1, `cpg_en`=1, `cpu_halt`=1, `mem_self_refresh`=0.
- R3: In run, a `sleep_stb` with `stby_sel`=1 enters software standby at the next edge: `mode_code`=2, `cpg_en`=0, `cpu_halt`=1, `per_clk_en`=0, `mem_self_refresh`=1.
- R4: In every mode, `rtc_clk_en` equals the value `rtc_start` had at the previous clock edge.
- R5: In run and in sleep, `per_clk_en[i]` is the inverse of `mod_stop[i]` from the previous edge. Stop bits never change `cpg_en`, `cpu_halt` or `mode_code`.
- R6: In sleep, any active wake request returns the block to run at the next edge. In run, wake requests have no effect.
- R7: A `wake_src` bit whose `WAKE_EDGE_MASK` bit is 1 counts only in the cycle after a low-to-high change (default mask: only bit 1). While such a source is held high, it neither wakes the block nor cancels an entry. A bit whose mask bit is 0 counts as long as it is high.
- R8: In software standby, a wake request starts settling at the next edge: `mode_code`=2, `cpg_en`=1, `cpu_halt`=1, `per_clk_en`=0, `mem_self_refresh`=1. Settling lasts `settle_cycles`+1 cycles, and the block is then in run.
- R9: A wake request in the same cycle as `sleep_stb` cancels the entry, and the block stays in run.
- R10: `hwstby_n` passes through a two-stage synchronizer. A low level enters hardware standby at the third edge after it is applied: `mode_code`=3, `cpg_en`=0, `cpu_halt`=1, `per_clk_en`=0, `mem_self_refresh`=1. This has priority over any other mode and over a wake request in the same cycle.
- R11: Hardware standby is kept while `hwstby_n` returns high, while wake requests arrive and while `mrst_n` is low. Only `rst_n` leaves it.
- R12: A low `mrst_n` for one cycle returns sleep to run at the next edge. It moves software standby into settling at the next edge, with `mem_self_refresh` still 1.
- R13: `mode_code` reads 0 in run, 1 in sleep, 2 in software standby and in settling, and 3 in hardware standby. `cpu_halt` is 0 only in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| sleep_stb | input | 1 | One-cycle SLEEP instruction strobe |
| stby_sel | input | 1 | 0 selects sleep, 1 selects software standby |
| mod_stop | input | NMOD | Per-module stop bits, 1 stops the module |
| rtc_start | input | 1 | Real-time-clock start bit |
| hwstby_n | input | 1 | Hardware-standby pin, active low, asynchronous |
| wake_src | input | NWAKE | Wake-up sources |
| settle_cycles | input | SETTLE_W | Settling length minus one, in cycles |
| cpg_en | output | 1 | Clock-generator enable |
| cpu_halt | output | 1 | CPU halt request |
| per_clk_en | output | NMOD | Per-peripheral clock gates |
| rtc_clk_en | output | 1 | Real-time-clock keep-alive gate |
| mem_self_refresh | output | 1 | 1 requests self-refresh, 0 auto-refresh |
| mode_code | output | 2 | Current mode code |

## Verification
Every output is registered from the next-state logic. A synchronous input applied before an edge is therefore visible right after that same edge. The hardware-standby pin appears only after the third edge, because of its two synchronizer stages. Settling ends `settle_cycles`+1 edges after it starts, and a power-on reset acts without waiting for an edge. The driver applies each stimulus on a falling edge and counts exactly that many rising edges. It then queues the expected output set, and the monitor compares it at the next falling edge. For the pin and for settling, extra checks one edge early confirm that nothing moves before its due cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_SWSTBY = 3'd2,
    ST_SETTLE = 3'd3,
    ST_HWSTBY = 3'd4
  } lpm_state_e;

  localparam logic [1:0] MODE_RUN    = 2'd0;
  localparam logic [1:0] MODE_SLEEP  = 2'd1;
  localparam logic [1:0] MODE_SWSTBY = 2'd2;
  localparam logic [1:0] MODE_HWSTBY = 2'd3;

  // per-state output policy
  typedef struct packed {
    logic       cpg_en;
    logic       cpu_halt;
    logic       per_run;   // peripherals follow their stop bits
    logic       self_ref;
    logic [1:0] mode;
  } lpm_policy_t;

  function automatic lpm_policy_t policy_of(lpm_state_e st);
    lpm_policy_t p;
    case (st)
      ST_RUN:    p = '{cpg_en: 1'b1, cpu_halt: 1'b0, per_run: 1'b1, self_ref: 1'b0, mode: MODE_RUN};
      ST_SLEEP:  p = '{cpg_en: 1'b1, cpu_halt: 1'b1, per_run: 1'b1, self_ref: 1'b0, mode: MODE_SLEEP};
      ST_SWSTBY: p = '{cpg_en: 1'b0, cpu_halt: 1'b1, per_run: 1'b0, self_ref: 1'b1, mode: MODE_SWSTBY};
      ST_SETTLE: p = '{cpg_en: 1'b1, cpu_halt: 1'b1, per_run: 1'b0, self_ref: 1'b1, mode: MODE_SWSTBY};
      ST_HWSTBY: p = '{cpg_en: 1'b0, cpu_halt: 1'b1, per_run: 1'b0, self_ref: 1'b1, mode: MODE_HWSTBY};
      default:   p = '{cpg_en: 1'b1, cpu_halt: 1'b0, per_run: 1'b1, self_ref: 1'b0, mode: MODE_RUN};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
  parameter int                NWAKE     = 5,
  parameter logic [NWAKE-1:0]  EDGE_MASK = 5'b00010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NWAKE-1:0] src,
  output logic             wake_any
);

  logic [NWAKE-1:0] req;

  for (genvar i = 0; i < NWAKE; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src[i];
      end
      assign req[i] = src[i] & ~prev_q;
    end else begin : g_level
      assign req[i] = src[i];
    end
  end

  assign wake_any = |req;

endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mrst_n,
  input  logic       sleep_stb,
  input  logic       stby_sel,
  input  logic       wake_any,
  input  logic       hw_n_sync,
  input  logic       settle_done,
  output logic       settle_load,
  output lpm_state_e state_d
);

  lpm_state_e state_q;

  always_comb begin
    state_d = state_q;
    if (!hw_n_sync) begin
      state_d = ST_HWSTBY;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (mrst_n && sleep_stb && !wake_any)
            state_d = stby_sel ? ST_SWSTBY : ST_SLEEP;
        end
        ST_SLEEP: begin
          if (!mrst_n || wake_any) state_d = ST_RUN;
        end
        ST_SWSTBY: begin
          if (!mrst_n || wake_any) state_d = ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_done) state_d = ST_RUN;
        end
        ST_HWSTBY: state_d = ST_HWSTBY;
        default:   state_d = ST_RUN;
      endcase
    end
  end

  assign settle_load = (state_d == ST_SETTLE) && (state_q != ST_SETTLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int               NMOD           = 4,
  parameter int               NWAKE          = 5,
  parameter logic [NWAKE-1:0] WAKE_EDGE_MASK = 5'b00010,
  parameter int               SETTLE_W       = 8,
  parameter int               SYNC_STAGES    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mrst_n,
  input  logic                sleep_stb,
  input  logic                stby_sel,
  input  logic [NMOD-1:0]     mod_stop,
  input  logic                rtc_start,
  input  logic                hwstby_n,
  input  logic [NWAKE-1:0]    wake_src,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                cpg_en,
  output logic                cpu_halt,
  output logic [NMOD-1:0]     per_clk_en,
  output logic                rtc_clk_en,
  output logic                mem_self_refresh,
  output logic [1:0]          mode_code
);

  localparam logic [NMOD-1:0] ALL_ON = {NMOD{1'b1}};

  logic        hw_n_sync;
  logic        wake_any;
  logic        settle_load;
  logic        settle_done;
  lpm_state_e  state_d;
  lpm_policy_t pol_d;
  logic [NMOD-1:0] per_d;

  lpm_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hw_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (hwstby_n),
    .q     (hw_n_sync)
  );

  lpm_wake_detect #(.NWAKE(NWAKE), .EDGE_MASK(WAKE_EDGE_MASK)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (wake_src),
    .wake_any (wake_any)
  );

  lpm_settle_timer #(.W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (settle_load),
    .load_val (settle_cycles),
    .done     (settle_done)
  );

  lpm_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .mrst_n      (mrst_n),
    .sleep_stb   (sleep_stb),
    .stby_sel    (stby_sel),
    .wake_any    (wake_any),
    .hw_n_sync   (hw_n_sync),
    .settle_done (settle_done),
    .settle_load (settle_load),
    .state_d     (state_d)
  );

  // outputs are registered from the next state, so they line up with it
  always_comb begin
    pol_d = policy_of(state_d);
    per_d = pol_d.per_run ? ~mod_stop : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpg_en           <= 1'b1;
      cpu_halt         <= 1'b0;
      per_clk_en       <= ALL_ON;
      rtc_clk_en       <= 1'b0;
      mem_self_refresh <= 1'b0;
      mode_code        <= MODE_RUN;
    end else begin
      cpg_en           <= pol_d.cpg_en;
      cpu_halt         <= pol_d.cpu_halt;
      per_clk_en       <= per_d;
      rtc_clk_en       <= rtc_start;
      mem_self_refresh <= pol_d.self_ref;
      mode_code        <= pol_d.mode;
    end
  end

endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk #(
  parameter int NMOD = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sleep_stb,
  input logic            wake_any,
  input logic            hw_n_sync,
  input logic            cpg_en,
  input logic            cpu_halt,
  input logic [NMOD-1:0] per_clk_en,
  input logic            mem_self_refresh,
  input logic [1:0]      mode_code
);

  assert_hw_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd3) |=> (mode_code == 2'd3));

  assert_hw_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_n_sync) |=> (mode_code == 2'd3));

  assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd0 && sleep_stb && wake_any && hw_n_sync) |=> (mode_code == 2'd0));

  assert_sleep_policy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd1) |-> (cpg_en && cpu_halt && !mem_self_refresh));

  assert_stby_policy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd2 && !cpg_en) |-> (cpu_halt && mem_self_refresh && per_clk_en == '0));

  assert_settle_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd2 && !cpg_en) |=> (mode_code != 2'd0));

  assert_run_only_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_halt) |-> (mode_code == 2'd0 && cpg_en && !mem_self_refresh));

endmodule

bind lpm_sequencer lpm_sequencer_chk #(.NMOD(NMOD)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .sleep_stb        (sleep_stb),
  .wake_any         (wake_any),
  .hw_n_sync        (hw_n_sync),
  .cpg_en           (cpg_en),
  .cpu_halt         (cpu_halt),
  .per_clk_en       (per_clk_en),
  .mem_self_refresh (mem_self_refresh),
  .mode_code        (mode_code)
);

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NMOD  = 4;
  localparam int NWAKE = 5;
  localparam int SW    = 8;

  logic            clk;
  logic            rst_n, mrst_n, sleep_stb, stby_sel, rtc_start, hwstby_n;
  logic [NMOD-1:0] mod_stop;
  logic [NWAKE-1:0] wake_src;
  logic [SW-1:0]   settle_cycles;
  logic            cpg_en, cpu_halt, rtc_clk_en, mem_self_refresh;
  logic [NMOD-1:0] per_clk_en;
  logic [1:0]      mode_code;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0]      mode;
    logic            cpg;
    logic            halt;
    logic [NMOD-1:0] per;
    logic            rtc;
    logic            sref;
    string           tag;
  } exp_t;

  exp_t exp_q[$];

  lpm_sequencer dut (
    .clk (clk), .rst_n (rst_n), .mrst_n (mrst_n), .sleep_stb (sleep_stb),
    .stby_sel (stby_sel), .mod_stop (mod_stop), .rtc_start (rtc_start),
    .hwstby_n (hwstby_n), .wake_src (wake_src), .settle_cycles (settle_cycles),
    .cpg_en (cpg_en), .cpu_halt (cpu_halt), .per_clk_en (per_clk_en),
    .rtc_clk_en (rtc_clk_en), .mem_self_refresh (mem_self_refresh),
    .mode_code (mode_code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic push(input logic [1:0] m, input logic c, input logic h,
                      input logic [NMOD-1:0] p, input logic r, input logic s,
                      input string tag);
    exp_t e;
    e.mode = m; e.cpg = c; e.halt = h; e.per = p; e.rtc = r; e.sref = s; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  // monitor: compares queued expectations away from the active edge
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        checks++;
        if (mode_code !== it.mode || cpg_en !== it.cpg || cpu_halt !== it.halt ||
            per_clk_en !== it.per || rtc_clk_en !== it.rtc || mem_self_refresh !== it.sref) begin
          failures++;
          $display("FAIL %s: got mode=%0d cpg=%b halt=%b per=%b rtc=%b sref=%b, expected mode=%0d cpg=%b halt=%b per=%b rtc=%b sref=%b",
                   it.tag, mode_code, cpg_en, cpu_halt, per_clk_en, rtc_clk_en, mem_self_refresh,
                   it.mode, it.cpg, it.halt, it.per, it.rtc, it.sref);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mrst_n = 1; sleep_stb = 0; stby_sel = 0; rtc_start = 0;
    hwstby_n = 1; mod_stop = '0; wake_src = '0; settle_cycles = 8'd3;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    push(2'd0, 1, 0, 4'b1111, 0, 0, "R1 reset state");
    @(negedge clk); rst_n = 1;

    // R5 stop bits in run
    @(negedge clk); mod_stop = 4'b0101; cyc(1);
    push(2'd0, 1, 0, 4'b1010, 0, 0, "R5 stop bits in run");
    @(negedge clk); mod_stop = 4'b0000; cyc(1);
    push(2'd0, 1, 0, 4'b1111, 0, 0, "R5 stop bits cleared");

    // R2 sleep entry, R5 in sleep, R6 wake
    @(negedge clk); sleep_stb = 1; stby_sel = 0; cyc(1);
    push(2'd1, 1, 1, 4'b1111, 0, 0, "R2 sleep entry");
    @(negedge clk); sleep_stb = 0; mod_stop = 4'b0010; cyc(1);
    push(2'd1, 1, 1, 4'b1101, 0, 0, "R5 stop bit in sleep");
    @(negedge clk); wake_src = 5'b00001; cyc(1);
    push(2'd0, 1, 0, 4'b1101, 0, 0, "R6 level wake from sleep");
    @(negedge clk); wake_src = '0; mod_stop = '0; cyc(1);
    push(2'd0, 1, 0, 4'b1111, 0, 0, "R6 back in run");
    @(negedge clk); wake_src = 5'b00001; cyc(2);
    push(2'd0, 1, 0, 4'b1111, 0, 0, "R6 wake ignored in run");
    @(negedge clk); wake_src = '0;

    // R9 cancel
    @(negedge clk); sleep_stb = 1; wake_src = 5'b00001; cyc(1);
    push(2'd0, 1, 0, 4'b1111, 0, 0, "R9 entry cancelled");
    @(negedge clk); sleep_stb = 0; wake_src = '0; cyc(1);
    push(2'd0, 1, 0, 4'b1111, 0, 0, "R9 still run");

    // R3 software standby, R4 rtc gate
    @(negedge clk); rtc_start = 1; stby_sel = 1; sleep_stb = 1; cyc(1);
    push(2'd2, 0, 1, 4'b0000, 1, 1, "R3 software standby entry");
    @(negedge clk); sleep_stb = 0; rtc_start = 0; cyc(1);
    push(2'd2, 0, 1, 4'b0000, 0, 1, "R4 rtc gate off");
    @(negedge clk); rtc_start = 1; cyc(1);
    push(2'd2, 0, 1, 4'b0000, 1, 1, "R4 rtc gate on");

    // R8 edge wake, settling for 3+1 cycles
    @(negedge clk); wake_src = 5'b00010; cyc(1);
    push(2'd2, 1, 1, 4'b0000, 1, 1, "R8 settling starts");
    cyc(3);
    push(2'd2, 1, 1, 4'b0000, 1, 1, "R8 still settling");
    cyc(1);
    push(2'd0, 1, 0, 4'b1111, 1, 0, "R8 run after settling");

    // R7 edge source held high
    @(negedge clk); stby_sel = 0; sleep_stb = 1; cyc(1);
    push(2'd1, 1, 1, 4'b1111, 1, 0, "R7 held edge source does not cancel");
    @(negedge clk); sleep_stb = 0; cyc(3);
    push(2'd1, 1, 1, 4'b1111, 1, 0, "R7 held edge source does not wake");
    @(negedge clk); wake_src = '0; cyc(1);
    push(2'd1, 1, 1, 4'b1111, 1, 0, "R7 falling edge does not wake");
    @(negedge clk); wake_src = 5'b00010; cyc(1);
    push(2'd0, 1, 0, 4'b1111, 1, 0, "R7 rising edge wakes");
    @(negedge clk); wake_src = '0;

    // R12 manual reset
    @(negedge clk); sleep_stb = 1; cyc(1);
    push(2'd1, 1, 1, 4'b1111, 1, 0, "R12 sleep before manual reset");
    @(negedge clk); sleep_stb = 0; mrst_n = 0; cyc(1);
    push(2'd0, 1, 0, 4'b1111, 1, 0, "R12 manual reset leaves sleep");
    @(negedge clk); mrst_n = 1; stby_sel = 1; sleep_stb = 1; cyc(1);
    push(2'd2, 0, 1, 4'b0000, 1, 1, "R12 standby before manual reset");
    @(negedge clk); sleep_stb = 0; mrst_n = 0; cyc(1);
    push(2'd2, 1, 1, 4'b0000, 1, 1, "R12 manual reset settles in self-refresh");
    @(negedge clk); mrst_n = 1; cyc(3);
    push(2'd2, 1, 1, 4'b0000, 1, 1, "R12 settling continues");
    cyc(1);
    push(2'd0, 1, 0, 4'b1111, 1, 0, "R12 run after settling");

    // R10 hardware standby through the synchronizer
    @(negedge clk); hwstby_n = 0; cyc(2);
    push(2'd0, 1, 0, 4'b1111, 1, 0, "R10 pin not yet seen");
    cyc(1);
    push(2'd3, 0, 1, 4'b0000, 1, 1, "R10 hardware standby");

    // R11 no exit but power-on reset
    @(negedge clk); hwstby_n = 1; wake_src = 5'b00001; mrst_n = 0; cyc(4);
    push(2'd3, 0, 1, 4'b0000, 1, 1, "R11 hardware standby held");
    @(negedge clk); mrst_n = 1; wake_src = '0;
    @(negedge clk); rst_n = 0; #1;
    push(2'd0, 1, 0, 4'b1111, 0, 0, "R1 power-on reset leaves hardware standby");
    @(negedge clk); rst_n = 1;

    // R10 priority over a wake request while in sleep
    @(negedge clk); stby_sel = 0; sleep_stb = 1; cyc(1);
    push(2'd1, 1, 1, 4'b1111, 1, 0, "R10 sleep before pin");
    @(negedge clk); sleep_stb = 0; hwstby_n = 0; cyc(2);
    push(2'd1, 1, 1, 4'b1111, 1, 0, "R10 sleep while pin synchronizes");
    @(negedge clk); wake_src = 5'b00001; cyc(1);
    push(2'd3, 0, 1, 4'b0000, 1, 1, "R10 pin wins over wake");
    @(negedge clk); wake_src = '0; hwstby_n = 1; rst_n = 0; #1;
    push(2'd0, 1, 0, 4'b1111, 0, 0, "R1 reset again");
    @(negedge clk); rst_n = 1;

    // R1 power-on reset aborts software standby
    @(negedge clk); stby_sel = 1; sleep_stb = 1; cyc(1);
    push(2'd2, 0, 1, 4'b0000, 1, 1, "R3 standby before power-on reset");
    @(negedge clk); sleep_stb = 0; rst_n = 0; #1;
    push(2'd0, 1, 0, 4'b1111, 0, 0, "R1 power-on reset aborts standby");
    @(negedge clk); rst_n = 1;

    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule